// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block holds the replacement state for an eight-way set-associative cache. Each set has a seven-node binary tree of pseudo-LRU bits. The cache presents a set index, the valid bits of that set's eight ways and a request for a victim. The block answers in the same cycle with the way to fill. An empty way always wins over the tree: the lowest-numbered way whose valid bit is clear is chosen. Only when all eight ways are occupied does the block walk the tree to reach a leaf.

Every access to a way updates the set's tree, whether it is a hit or the fill that loads a new line. The update rewrites only the three nodes on the path to that way and takes effect at the next clock edge. Tags, data and valid bits live outside the block. A synchronous reset returns every tree to all zeros.

Top module: `plru8_sel`

## Requirements
- R1: A synchronous reset sets every tree bit of every set to 0. After reset, a victim request on any set with all ways valid returns way 0.
- R2: When `valid_mask` is not 8'hFF, the victim is the lowest-numbered way whose `valid_mask` bit is 0. Bit i of `valid_mask` belongs to way i.
- R3: When `valid_mask` is 8'hFF, the victim comes from the tree bits t0..t6. If t0=1 and t2=1, the victim is way 7 when t6=1 and way 6 when t6=0. If t0=1 and t2=0, it is way 5 when t5=1 and way 4 when t5=0. If t0=0 and t1=1, it is way 3 when t4=1 and way 2 when t4=0. If t0=0 and t1=0, it is way 1 when t3=1 and way 0 when t3=0.
- R4: An access to a way rewrites exactly three tree bits, as follows:
  - way 0 sets t0, t1 and t3.
  - way 1 sets t0 and t1 and clears t3.
  - way 2 sets t0 and t4 and clears t1.
  - way 3 sets t0 and clears t1 and t4.
  - way 4 sets t2 and t5 and clears t0.
  - way 5 sets t2 and clears t0 and t5.
  - way 6 sets t6 and clears t0 and t2.
  - way 7 clears t0, t2 and t6.
  - All other bits keep their values.
- R5: Only the set addressed by `set_idx` changes, and only while `acc_en` is 1. With `acc_en` at 0, no tree bit changes.
- R6: `victim_way` is combinational from the current state. An access changes the tree from the next rising clock edge on.
- R7: While `victim_req` is 0, `victim_way` is 0.
- R8: A fill access, in which `acc_way` equals the victim just returned, updates the tree by the same rule as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_idx | input | $clog2(SETS) | Set addressed for both the access and the victim |
| acc_en | input | 1 | Access strobe; updates the tree of `set_idx` |
| acc_way | input | 3 | Way that was accessed |
| valid_mask | input | 8 | Valid bits of the addressed set, bit i = way i |
| victim_req | input | 1 | Victim request |
| victim_way | output | 3 | Way to fill |

## Verification
The bench sweeps every partially valid mask. A selector that preferred the tree, or picked the highest free way, would return an occupied or wrong way there. Long random runs of hits and fills over a small set count drive each tree into all reachable states. These runs compare every victim with an arithmetic model, so a swapped leaf bit or an update that disturbs a fourth node shows up as a wrong way later. Idle cycles with the strobe low, accesses to neighbouring sets and a reset in the middle of a run catch state that leaks between sets or survives reset.

// File: rtl/plru8_pkg.sv
package plru8_pkg;
    localparam int WAYS   = 8;
    localparam int WAY_W  = 3;
    localparam int NODES  = WAYS - 1;

    typedef logic [NODES-1:0] tree_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WAYS-1:0]  vmask_t;
endpackage

// File: rtl/plru8_tree_walk.sv
module plru8_tree_walk
    import plru8_pkg::*;
(
    input  tree_t tree,
    output way_t  leaf_way
);
    logic       upper;
    logic       mid;
    int unsigned leaf_node;

    always_comb begin
        upper     = tree[0];
        mid       = upper ? tree[2] : tree[1];
        leaf_node = upper ? (tree[2] ? 6 : 5) : (tree[1] ? 4 : 3);
        leaf_way  = {upper, mid, tree[leaf_node]};
    end
endmodule

// File: rtl/plru8_first_free.sv
module plru8_first_free
    import plru8_pkg::*;
(
    input  vmask_t valid_mask,
    output logic   any_free,
    output way_t   free_way
);
    always_comb begin
        any_free = ~&valid_mask;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_mask[w]) free_way = way_t'(w);
        end
    end
endmodule

// File: rtl/plru8_tree_update.sv
module plru8_tree_update
    import plru8_pkg::*;
(
    input  tree_t cur_tree,
    input  way_t  way,
    output tree_t new_tree
);
    int unsigned half_node;
    int unsigned leaf_node;

    always_comb begin
        half_node = way[2] ? 2 : 1;
        leaf_node = way[2] ? (way[1] ? 6 : 5) : (way[1] ? 4 : 3);
        new_tree            = cur_tree;
        new_tree[0]         = ~way[2];
        new_tree[half_node] = ~way[1];
        new_tree[leaf_node] = ~way[0];
    end
endmodule

// File: rtl/plru8_sel.sv
module plru8_sel
    import plru8_pkg::*;
#(
    parameter int SETS  = 128,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             acc_en,
    input  logic [2:0]       acc_way,
    input  logic [7:0]       valid_mask,
    input  logic             victim_req,
    output logic [2:0]       victim_way
);
    typedef struct packed {
        logic [SETS-1:0][NODES-1:0] tree;
    } state_t;

    state_t st_d, st_q;

    tree_t cur_tree;
    tree_t upd_tree;
    way_t  walk_way;
    way_t  free_way;
    logic  any_free;

    assign cur_tree = st_q.tree[set_idx];

    plru8_tree_walk i_walk (
        .tree     (cur_tree),
        .leaf_way (walk_way)
    );

    plru8_first_free i_free (
        .valid_mask (valid_mask),
        .any_free   (any_free),
        .free_way   (free_way)
    );

    plru8_tree_update i_upd (
        .cur_tree (cur_tree),
        .way      (acc_way),
        .new_tree (upd_tree)
    );

    always_comb begin
        st_d = st_q;
        if (acc_en) st_d.tree[set_idx] = upd_tree;
        if (!victim_req)   victim_way = '0;
        else if (any_free) victim_way = free_way;
        else               victim_way = walk_way;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    free_way_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (victim_req && valid_mask != 8'hFF) |-> !valid_mask[victim_way]);

    // R2
    free_way_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (victim_req && valid_mask != 8'hFF) |->
            ((valid_mask & ((8'd1 << victim_way) - 8'd1)) == ((8'd1 << victim_way) - 8'd1)));

    // R4
    three_nodes_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> ($countones(st_q.tree[$past(set_idx)] ^ $past(cur_tree)) <= 3));

    // R4
    walk_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> ($past(acc_way) != {st_q.tree[$past(set_idx)][0],
            (st_q.tree[$past(set_idx)][0] ? st_q.tree[$past(set_idx)][2]
                                          : st_q.tree[$past(set_idx)][1]),
            $past(acc_way[0])}));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> $stable(st_q));

    // R7
    idle_victim_chk: assert property (@(posedge clk) disable iff (rst)
        !victim_req |-> (victim_way == 3'd0));
endmodule

// File: tb/test_plru8_sel.sv
module test_plru8_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 8;
    localparam int SW = $clog2(NSETS);

    logic          clk = 1'b0;
    logic          rst;
    logic [SW-1:0] set_idx;
    logic          acc_en;
    logic [2:0]    acc_way;
    logic [7:0]    valid_mask;
    logic          victim_req;
    logic [2:0]    victim_way;

    int checks = 0;
    int fails  = 0;
    logic [6:0] model [NSETS];
    logic [31:0] lfsr = 32'h1D2C3B4A;

    always #(CLK_PERIOD/2) clk = ~clk;

    plru8_sel #(.SETS(NSETS)) i_plru8_sel (
        .clk(clk), .rst(rst), .set_idx(set_idx), .acc_en(acc_en),
        .acc_way(acc_way), .valid_mask(valid_mask),
        .victim_req(victim_req), .victim_way(victim_way)
    );

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    function automatic logic [2:0] exp_victim(logic [6:0] t, logic [7:0] vm, logic req);
        if (!req) return 3'd0;
        if (vm != 8'hFF) begin
            for (int w = 0; w < 8; w++) if (!vm[w]) return 3'(w);
        end
        if (t[0]) begin
            if (t[2]) return t[6] ? 3'd7 : 3'd6;
            else      return t[5] ? 3'd5 : 3'd4;
        end else begin
            if (t[1]) return t[4] ? 3'd3 : 3'd2;
            else      return t[3] ? 3'd1 : 3'd0;
        end
    endfunction

    function automatic logic [6:0] exp_update(logic [6:0] t, logic [2:0] w);
        logic [6:0] m, v;
        case (w)
            3'd0: begin m = 7'h0B; v = 7'h0B; end
            3'd1: begin m = 7'h0B; v = 7'h03; end
            3'd2: begin m = 7'h13; v = 7'h11; end
            3'd3: begin m = 7'h13; v = 7'h01; end
            3'd4: begin m = 7'h25; v = 7'h24; end
            3'd5: begin m = 7'h25; v = 7'h04; end
            3'd6: begin m = 7'h45; v = 7'h40; end
            default: begin m = 7'h45; v = 7'h00; end
        endcase
        return (t & ~m) | v;
    endfunction

    // Drive at negedge, check before the edge, then update the model after it.
    task automatic step(input int s, input logic en, input logic [2:0] w,
                        input logic [7:0] vm, input logic req, input string tag);
        logic [2:0] e;
        @(negedge clk);
        set_idx = SW'(s); acc_en = en; acc_way = w; valid_mask = vm; victim_req = req;
        #1;
        e = exp_victim(model[s], vm, req);
        checks++;
        if (victim_way !== e) begin
            fails++;
            $display("FAIL %s set %0d mask %h: victim %0d expected %0d", tag, s, vm, victim_way, e);
        end
        @(posedge clk);
        if (en) model[s] = exp_update(model[s], w);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_en = 1'b0; victim_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < NSETS; s++) model[s] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; set_idx = '0; acc_en = 1'b0; acc_way = '0;
        valid_mask = 8'hFF; victim_req = 1'b0;
        for (int s = 0; s < NSETS; s++) model[s] = '0;
        do_reset();

        // R1: every set starts with a cleared tree
        for (int s = 0; s < NSETS; s++) step(s, 1'b0, 3'd0, 8'hFF, 1'b1, "R1");

        // R2: sweep of every mask with at least one free way
        for (int m = 0; m < 255; m++) step(m % NSETS, 1'b0, 3'd0, 8'(m), 1'b1, "R2");

        // R7: no request gives way 0 whatever the state
        for (int s = 0; s < NSETS; s++) step(s, 1'b1, 3'(s), 8'h0F, 1'b0, "R7");

        // R4 R3: each single way access from a known state
        for (int w = 0; w < 8; w++) begin
            step(0, 1'b1, 3'(w), 8'hFF, 1'b1, "R4");
            step(0, 1'b0, 3'd0, 8'hFF, 1'b1, "R3 R4");
        end

        // R5: strobe low with changing way must leave the trees unchanged
        for (int i = 0; i < 32; i++)
            step(i % NSETS, 1'b0, 3'(rnd()), 8'hFF, 1'b1, "R5");

        // R3 R4 R5 R6 R8: random hits and fills across sets
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] r;
            int s;
            logic [7:0] vm;
            r = rnd();
            s = int'(r[2:0]) % NSETS;
            vm = (r[7:4] == 4'd0) ? 8'(rnd()) : 8'hFF;
            if (r[9:8] == 2'd0) begin
                // R8: fill the way the selector names
                step(s, 1'b1, exp_victim(model[s], vm, 1'b1), vm, 1'b1, "R8");
            end else begin
                step(s, r[10] | r[11], 3'(r[14:12]), vm, r[15] | r[16], "R3 R4 R5 R6");
            end
        end

        // R6: the access cycle still shows the old choice, the next one the new
        step(3, 1'b1, 3'd0, 8'hFF, 1'b1, "R6");
        step(3, 1'b1, 3'd7, 8'hFF, 1'b1, "R6");
        step(3, 1'b0, 3'd0, 8'hFF, 1'b1, "R6");

        // R1: reset in the middle of a run
        do_reset();
        for (int s = 0; s < NSETS; s++) step(s, 1'b0, 3'd0, 8'hFF, 1'b1, "R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule